// File: doc/BRIEF.md
# Eight-Function ALU with Condition Flags

This block is the arithmetic and logic unit of a simple single-bus datapath. It is combinational at its core. One operand comes from the holding register in front of the unit, and the other comes from the shared bus. A 3-bit operation code selects one of eight functions. The unit returns a result word and four condition flags: negative, zero, overflow and carry.

An optional register stage holds the condition code. When its load strobe is high, it captures the four flags at the clock edge. A compare is a subtract issued with the load strobe high while the result word is left unused. The datapath keeps its own registers unchanged, and only the condition code moves.

Top module: `cond_alu`

## Requirements
- R1: Operation code 000 (add) gives result = Y + B modulo 2^16. Carry is bit 16 of the 17-bit sum.
- R2: Operation code 001 (subtract) gives result = Y + ~B + 1, which is Y - B. Carry is bit 16 of that 17-bit sum, so it is a carry and not a borrow (1 when Y >= B unsigned).
- R3: For the arithmetic codes 000, 001, 101 and 111, overflow = (x15 & y15 & ~s15) | (~x15 & ~y15 & s15). Here x and y are the two adder inputs after any inversion, and s is the sum. The adder inputs are (Y,B) for add, (Y,~B) for subtract, (~Y,0) for negate and (B,0) for increment.
- R4: Code 010 gives Y & B, code 011 gives Y | B, and code 100 gives ~Y.
- R5: Code 101 (negate) gives ~Y + 1. Code 111 (increment) gives B + 1. Carry for each is bit 16 of its 17-bit adder sum.
- R6: Code 110 passes B to the result unchanged.
- R7: The negative flag equals bit 15 of the result.
- R8: The zero flag is 1 exactly when all 16 result bits are 0.
- R9: For codes 010, 011, 100 and 110, overflow and carry are both 0.
- R10: With CC_REG=1, the condition code output {N,Z,V,C} (bit 3 down to bit 0) takes the live flags at a rising clock edge when flag_load is high. It holds its value when flag_load is low.
- R11: A low rst_n at a rising edge clears the condition code to 0000, even when flag_load is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the condition code register |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Operation code |
| y_opnd | input | 16 | Operand A from the holding register |
| bus_opnd | input | 16 | Operand B from the bus |
| flag_load | input | 1 | Capture live flags into the condition code |
| result | output | 16 | Result word |
| flags_now | output | 4 | Live flags {N,Z,V,C} for the current inputs |
| cc_q | output | 4 | Registered condition code {N,Z,V,C} |

## Verification
Two events can land on the same edge: a condition code capture, and a synchronous reset or a new operation whose flags differ from those being held. The bench changes the operation and operands on every cycle, with a random load strobe, so the register must keep the flags of the last loaded operation and not those of the current one. It also raises flag_load while rst_n is low, with operands chosen to produce non-zero flags, and expects 0000 on the next cycle. Results and flags are compared with values from bench functions, both for seeded random operands and for edge values such as 0x7FFF, 0x8000, 0xFFFF and zero.

// File: rtl/cond_alu_pkg.sv
// Package: shared operation codes and flag layout for the ALU.
// Assumes the flag vector order {N,Z,V,C}, with N in bit 3.
package cond_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_NOTA = 3'b100,
        OP_NEGA = 3'b101,
        OP_PASS = 3'b110,
        OP_INCB = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    // True for the codes that go through the adder.
    function automatic logic op_is_arith(alu_op_e o);
        return (o == OP_ADD) || (o == OP_SUB) || (o == OP_NEGA) || (o == OP_INCB);
    endfunction

endpackage

// File: rtl/cond_alu_adder.sv
// Adder path: chooses the adder inputs and carry-in for add, subtract,
// negate and increment, then forms the sum, carry out and overflow.
// Assumes the two's-complement overflow rule on the adder inputs.
module cond_alu_adder
    import cond_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);
    localparam int XW = W + 1;

    logic [W-1:0]  x_in;
    logic [W-1:0]  y_in;
    logic          c_in;
    logic [XW-1:0] ext;

    // Pick the adder inputs and carry-in for the selected operation.
    always_comb begin
        x_in = a;
        y_in = b;
        c_in = 1'b0;
        unique case (op)
            OP_SUB:  begin x_in = a;  y_in = ~b;        c_in = 1'b1; end
            OP_NEGA: begin x_in = ~a; y_in = '0;        c_in = 1'b1; end
            OP_INCB: begin x_in = b;  y_in = '0;        c_in = 1'b1; end
            default: begin x_in = a;  y_in = b;         c_in = 1'b0; end
        endcase
    end

    // Extended sum, one bit wider than the operands.
    always_comb begin
        ext = {1'b0, x_in} + {1'b0, y_in} + {{(XW-1){1'b0}}, c_in};
    end

    // Split the sum into result bits, carry and sign overflow.
    always_comb begin
        sum  = ext[W-1:0];
        cout = ext[W];
        ovf  = (x_in[W-1] & y_in[W-1] & ~ext[W-1]) |
               (~x_in[W-1] & ~y_in[W-1] & ext[W-1]);
    end

endmodule

// File: rtl/cond_alu_logic.sv
// Logic path: AND, OR, invert and pass-through. It carries no flags
// of its own. Assumes the caller selects this output only for the
// logic codes.
module cond_alu_logic
    import cond_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    // Bitwise function selected by the operation code.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_NOTA: res = ~a;
            OP_PASS: res = b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/cond_alu_flags.sv
// Flag former: N and Z from the result, and V and C from the adder
// for arithmetic codes only. Flags are forced to 0 otherwise.
module cond_alu_flags
    import cond_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    input  logic         arith,
    input  logic         cout,
    input  logic         ovf,
    output cc_t          flg
);
    // Assemble the four condition flags.
    always_comb begin
        flg.n = res[W-1];
        flg.z = (res == '0);
        flg.v = arith & ovf;
        flg.c = arith & cout;
    end

endmodule

// File: rtl/cond_alu.sv
// Top: eight-function ALU with live flags and an optional condition
// code register (CC_REG). The register uses a synchronous active-low
// reset and loads on flag_load.
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int W      = 16,
    parameter bit CC_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op,
    input  logic [W-1:0] y_opnd,
    input  logic [W-1:0] bus_opnd,
    input  logic         flag_load,
    output logic [W-1:0] result,
    output logic [3:0]   flags_now,
    output logic [3:0]   cc_q
);
    alu_op_e       op_e;
    logic [W-1:0]  add_sum;
    logic          add_cout;
    logic          add_ovf;
    logic [W-1:0]  lgc_res;
    logic          arith;
    cc_t           flg;

    // Decode the raw code into the shared enum.
    always_comb begin
        op_e  = alu_op_e'(op);
        arith = op_is_arith(op_e);
    end

    cond_alu_adder #(.W(W)) adder_i (
        .op   (op_e),
        .a    (y_opnd),
        .b    (bus_opnd),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    cond_alu_logic #(.W(W)) logic_i (
        .op  (op_e),
        .a   (y_opnd),
        .b   (bus_opnd),
        .res (lgc_res)
    );

    // Choose the adder or the logic path for the result.
    always_comb begin
        result = arith ? add_sum : lgc_res;
    end

    cond_alu_flags #(.W(W)) flags_i (
        .res   (result),
        .arith (arith),
        .cout  (add_cout),
        .ovf   (add_ovf),
        .flg   (flg)
    );

    // Export the live flags.
    always_comb begin
        flags_now = flg;
    end

    generate
        if (CC_REG) begin : g_ccreg
            cc_t cc_r;
            // Condition code register: reset clears it, load captures.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cc_r <= '0;
                else if (flag_load)
                    cc_r <= flg;
            end
            // Drive the output from the register.
            always_comb cc_q = cc_r;
        end else begin : g_ccwire
            // No register: the condition code follows the live flags.
            always_comb cc_q = flg;
        end
    endgenerate

endmodule

// File: rtl/cond_alu_chk.sv
// Checker: properties on the ALU ports, attached with bind.
module cond_alu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op,
    input logic         flag_load,
    input logic [W-1:0] result,
    input logic [3:0]   flags_now,
    input logic [3:0]   cc_q
);
    // R7: negative flag follows the result sign bit
    a_r7_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[3] == result[W-1]);

    // R8: zero flag matches an all-zero result
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[2] == (result == '0));

    // R9: logical and pass codes leave V and C clear
    a_r9_no_vc_logic: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'b010 || op == 3'b011 || op == 3'b100 || op == 3'b110)
        |-> (flags_now[1:0] == 2'b00));

    // R10: loaded value equals the flags seen on the load edge
    a_r10_cc_load: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (cc_q == $past(flags_now)));

    // R10: no load keeps the held code
    a_r10_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> $stable(cc_q));

    // R11: reset clears the code on the following cycle
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cc_q == 4'b0000));

endmodule

bind cond_alu cond_alu_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .flag_load (flag_load),
    .result    (result),
    .flags_now (flags_now),
    .cc_q      (cc_q)
);

// File: tb/cond_alu_tb_top.sv
module cond_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [15:0] y_opnd = '0;
    logic [15:0] bus_opnd = '0;
    logic        flag_load = 1'b0;
    logic [15:0] result;
    logic [3:0]  flags_now;
    logic [3:0]  cc_q;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] cc_model = 4'b0000;

    always #5 clk = ~clk;

    cond_alu #(.W(16), .CC_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op(op), .y_opnd(y_opnd),
        .bus_opnd(bus_opnd), .flag_load(flag_load),
        .result(result), .flags_now(flags_now), .cc_q(cc_q)
    );

    // Expected result from the requirement text.
    function automatic logic [15:0] exp_res(logic [2:0] o, logic [15:0] a, logic [15:0] b);
        case (o)
            3'b000: return a + b;            // R1
            3'b001: return a - b;            // R2
            3'b010: return a & b;            // R4
            3'b011: return a | b;            // R4
            3'b100: return ~a;               // R4
            3'b101: return 16'd0 - a;        // R5
            3'b110: return b;                // R6
            default: return b + 16'd1;       // R5
        endcase
    endfunction

    // Expected {N,Z,V,C} from the requirement text.
    function automatic logic [3:0] exp_flg(logic [2:0] o, logic [15:0] a, logic [15:0] b);
        logic [15:0] x, y, r;
        logic [16:0] s;
        logic ar, v, c;
        ar = 1'b1; x = a; y = b; s = '0;
        case (o)
            3'b000: begin x = a;  y = b;  s = {1'b0, a} + {1'b0, b}; end
            3'b001: begin x = a;  y = ~b; s = {1'b0, a} + {1'b0, ~b} + 17'd1; end
            3'b101: begin x = ~a; y = '0; s = {1'b0, ~a} + 17'd1; end
            3'b111: begin x = b;  y = '0; s = {1'b0, b} + 17'd1; end
            default: ar = 1'b0;
        endcase
        r = exp_res(o, a, b);
        v = ar & ((x[15] & y[15] & ~s[15]) | (~x[15] & ~y[15] & s[15]));
        c = ar & s[16];
        return {r[15], (r == 16'd0), v, c};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive one operation on a falling edge and check it; then let the
    // rising edge pass and update the condition code model.
    task automatic step(logic [2:0] o, logic [15:0] a, logic [15:0] b, logic ld);
        @(negedge clk);
        check("R10 cc held/loaded", {12'd0, cc_q}, {12'd0, cc_model});
        op = o; y_opnd = a; bus_opnd = b; flag_load = ld;
        #1;
        check(o == 3'b110 ? "R6 result" : (o[2] ? "R5/R4 result" : "R1/R2/R4 result"),
              result, exp_res(o, a, b));
        check("R3/R7/R8/R9 flags", {12'd0, flags_now}, {12'd0, exp_flg(o, a, b)});
        @(posedge clk);
        if (ld) cc_model = exp_flg(o, a, b);
    endtask

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset state", {12'd0, cc_q}, 16'd0);
        rst_n = 1'b1;
        // Directed corners
        step(3'b000, 16'h7FFF, 16'h0001, 1'b1); // R1 R3 signed overflow
        step(3'b000, 16'hFFFF, 16'h0001, 1'b1); // R1 carry, R8 zero
        step(3'b001, 16'h0000, 16'h0001, 1'b1); // R2 no carry (borrow case)
        step(3'b001, 16'h0005, 16'h0005, 1'b1); // R2 carry set, zero
        step(3'b001, 16'h8000, 16'h0001, 1'b0); // R3 overflow on subtract
        step(3'b101, 16'h8000, 16'h0000, 1'b1); // R5 negate of most negative
        step(3'b101, 16'h0000, 16'h0000, 1'b1); // R5 negate zero, carry
        step(3'b111, 16'h0000, 16'hFFFF, 1'b1); // R5 increment wrap
        step(3'b111, 16'h0000, 16'h7FFF, 1'b0); // R5 increment overflow
        step(3'b010, 16'hF0F0, 16'h0F0F, 1'b1); // R4 AND zero, R9
        step(3'b011, 16'h8000, 16'h0001, 1'b1); // R4 OR negative
        step(3'b100, 16'h0000, 16'h1234, 1'b1); // R4 NOT, R9
        step(3'b110, 16'hAAAA, 16'h0000, 1'b1); // R6 pass zero
        // R11: reset and load together, with non-zero live flags
        @(negedge clk);
        op = 3'b000; y_opnd = 16'h8000; bus_opnd = 16'h8000; flag_load = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset beats load", {12'd0, cc_q}, 16'd0);
        rst_n = 1'b1; flag_load = 1'b0;
        cc_model = 4'b0000;
        // Seeded random mix
        for (int i = 0; i < 3000; i++) begin
            step(3'($urandom()), 16'($urandom()), 16'($urandom()), 1'($urandom()));
        end
        @(negedge clk);
        check("R10 final cc", {12'd0, cc_q}, {12'd0, cc_model});
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule